// File: doc/BRIEF.md
# Interrupt Collector with Read Freeze and Refill Pipeline

This block gathers three kinds of events and turns them into one active-low interrupt line. The event kinds are per-channel input-change events, per-channel overcurrent events and two temperature-level events. Each kind is recorded in its own message register. Channels are grouped into nibbles. Each nibble is either an input group or an output group. Input-change events count only on input pins, and overcurrent events count only on output pins. A status byte summarises what is pending and also carries the live temperature and overcurrent levels.

A read strobe for a message register freezes that register. This lets the host see a stable snapshot of it. Events that arrive while the register is frozen are OR-collected in a one-deep shadow copy. An end-of-interrupt strobe unfreezes every register and loads it from its shadow copy. The interrupt line therefore stays low whenever anything was caught in the meantime. The end-of-interrupt command is a strobe that lasts one cycle, so it acts once and leaves no state behind. Bus decoding is done outside the block.

Top module: `irq_collect`

## Requirements
- R1: An input-change event on channel i is recorded only if chg_en[i] is 1 and the channel's nibble is in input mode. nib_out bit g is 1 when nibble g (channels 4g..4g+3) is in output mode. chg_msg always reads 0 for output-mode channels.
- R2: An overcurrent event on channel i is recorded only if oc_en[i] is 1 and the channel's nibble is in output mode. oc_msg always reads 0 for input-mode channels.
- R3: Temperature events have no mask. temp_evt[0] (level 1) latches into stat bit 5, and temp_evt[1] (level 2) latches into stat bit 6.
- R4: int_n is 0 whenever any message register, any latched temperature bit or any shadow copy holds a 1. Otherwise int_n is 1.
- R5: In stat, bit 7 is the OR of chg_msg and bit 4 is the OR of oc_msg. Bit 2 is live_temp[1], bit 1 is live_temp[0], and bit 0 is the OR of live_oc. Bit 3 is 0.
- R6: A read strobe (rd_chg, rd_oc or rd_stat, where rd_stat covers the temperature bits) freezes its register until end-of-interrupt. Events that are qualified in the strobe cycle or later go to the shadow copy and not to the register.
- R7: An eoi strobe loads every register from its shadow copy OR the events of that same cycle, empties all shadow copies and unfreezes everything. If eoi and a read strobe fall in the same cycle, eoi wins.
- R8: While chg_en[i] or oc_en[i] is 0, the matching bit is cleared in both the register and the shadow copy. Setting the enable again does not bring the bit back.
- R9: A change of any nibble's mode clears all message registers, temperature latches and shadow copies. Events in that cycle are dropped.
- R10: While rst_n is low, every register, shadow copy and freeze flag is cleared and int_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_evt | input | NCH | Input-change event pulses |
| oc_evt | input | NCH | Overcurrent event pulses |
| temp_evt | input | 2 | Temperature event pulses, [0] level 1, [1] level 2 |
| chg_en | input | NCH | Input-change enables |
| oc_en | input | NCH | Overcurrent enables |
| nib_out | input | NCH/GRP | Per-nibble mode, 1 = output |
| rd_chg | input | 1 | Read strobe for the input-change register |
| rd_oc | input | 1 | Read strobe for the overcurrent register |
| rd_stat | input | 1 | Read strobe for the status byte |
| eoi | input | 1 | End-of-interrupt strobe |
| live_temp | input | 2 | Live temperature levels |
| live_oc | input | NCH | Live per-channel overcurrent |
| chg_msg | output | NCH | Input-change message register |
| oc_msg | output | NCH | Overcurrent message register |
| stat | output | 8 | Status byte |
| int_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of functions can land in the same cycle, and the bench drives both on purpose. The first pair is a read strobe and a new event: the event must be routed to the shadow copy, so the register stays the same while int_n stays low, and the event only shows up after the next eoi. The second pair is a read strobe and eoi: eoi must win, so the register is cleared and not frozen, and int_n rises in the following cycle. Both cases appear as rows in the vector table, each with its expected register, status and interrupt values. A status-read row with a level-2 temperature event in the same cycle covers the same collision for the temperature bits.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
   // status byte bit positions (host software decodes these)
   localparam int ST_CHG = 7;
   localparam int ST_T2  = 6;
   localparam int ST_T1  = 5;
   localparam int ST_OC  = 4;
   localparam int ST_LT2 = 2;
   localparam int ST_LT1 = 1;
   localparam int ST_LOC = 0;
   localparam int ST_W   = 8;
   localparam int N_TEMP = 2;
endpackage

// File: rtl/irq_mode_map.sv
module irq_mode_map #(
   parameter int NCH = 8,
   parameter int GRP = 4,
   localparam int NG = NCH / GRP
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NG-1:0]  nib_out,
   output logic [NCH-1:0] ch_out,
   output logic           flip
);
   logic [NG-1:0] nib_q;

   // expand each nibble's mode onto its channels
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ch_out[i] = nib_out[i / GRP];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nib_q <= '0;
      else        nib_q <= nib_out;
   end

   assign flip = (nib_q != nib_out);
endmodule

// File: rtl/irq_msg_bank.sv
module irq_msg_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] keep,
   input  logic         rd,
   input  logic         eoi,
   input  logic         flush,
   output logic [W-1:0] q,
   output logic         pipe_any
);
   logic [W-1:0] p;
   logic         frz;
   logic         frz_eff;

   assign frz_eff  = frz | rd;
   assign pipe_any = |p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         p   <= '0;
         frz <= 1'b0;
      end else if (flush) begin
         q   <= '0;
         p   <= '0;
         frz <= 1'b0;
      end else if (eoi) begin
         q   <= (p | evt) & keep;
         p   <= '0;
         frz <= 1'b0;
      end else if (frz_eff) begin
         q   <= q & keep;
         p   <= (p | evt) & keep;
         frz <= 1'b1;
      end else begin
         q   <= (q | evt) & keep;
         frz <= 1'b0;
         p   <= p & keep;
      end
   end

   p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !eoi && !flush) |=> ((q & ~$past(q)) == '0));
   p_eoi_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !flush) |=> (p == '0));
   p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (((q | p) & ~$past(keep)) == '0));
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (q == '0 && p == '0));
endmodule

// File: rtl/irq_collect.sv
module irq_collect
   import irq_collect_pkg::*;
#(
   parameter int NCH = 8,
   parameter int GRP = 4,
   localparam int NG = NCH / GRP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  chg_evt,
   input  logic [NCH-1:0]  oc_evt,
   input  logic [1:0]      temp_evt,
   input  logic [NCH-1:0]  chg_en,
   input  logic [NCH-1:0]  oc_en,
   input  logic [NG-1:0]   nib_out,
   input  logic            rd_chg,
   input  logic            rd_oc,
   input  logic            rd_stat,
   input  logic            eoi,
   input  logic [1:0]      live_temp,
   input  logic [NCH-1:0]  live_oc,
   output logic [NCH-1:0]  chg_msg,
   output logic [NCH-1:0]  oc_msg,
   output logic [ST_W-1:0] stat,
   output logic            int_n
);
   if (NCH % GRP != 0 || NCH < 1 || GRP < 1) begin : g_bad_cfg
      $error("irq_collect: NCH must be a positive multiple of GRP");
   end

   logic [NCH-1:0]    ch_out;
   logic              flip;
   logic [NCH-1:0]    chg_q, oc_q;
   logic [N_TEMP-1:0] tmp_q;
   logic              chg_pa, oc_pa, tmp_pa;

   irq_mode_map #(.NCH(NCH), .GRP(GRP)) map_i (
      .clk(clk), .rst_n(rst_n), .nib_out(nib_out), .ch_out(ch_out), .flip(flip));

   irq_msg_bank #(.W(NCH)) chg_i (
      .clk(clk), .rst_n(rst_n), .evt(chg_evt & ~ch_out), .keep(chg_en),
      .rd(rd_chg), .eoi(eoi), .flush(flip), .q(chg_q), .pipe_any(chg_pa));

   irq_msg_bank #(.W(NCH)) oc_i (
      .clk(clk), .rst_n(rst_n), .evt(oc_evt & ch_out), .keep(oc_en),
      .rd(rd_oc), .eoi(eoi), .flush(flip), .q(oc_q), .pipe_any(oc_pa));

   irq_msg_bank #(.W(N_TEMP)) tmp_i (
      .clk(clk), .rst_n(rst_n), .evt(temp_evt), .keep({N_TEMP{1'b1}}),
      .rd(rd_stat), .eoi(eoi), .flush(flip), .q(tmp_q), .pipe_any(tmp_pa));

   assign chg_msg = chg_q & ~ch_out;
   assign oc_msg  = oc_q & ch_out;

   always_comb begin
      stat         = '0;
      stat[ST_CHG] = |chg_msg;
      stat[ST_T2]  = tmp_q[1];
      stat[ST_T1]  = tmp_q[0];
      stat[ST_OC]  = |oc_msg;
      stat[ST_LT2] = live_temp[1];
      stat[ST_LT1] = live_temp[0];
      stat[ST_LOC] = |live_oc;
   end

   assign int_n = ~(|chg_q | |oc_q | |tmp_q | chg_pa | oc_pa | tmp_pa);

   p_int_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|chg_msg) || (|oc_msg) || stat[ST_T2] || stat[ST_T1]) |-> !int_n);
   p_chg_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> ((chg_q & ~$past(chg_q) & ~$past(chg_en)) == '0));
endmodule

// File: tb/irq_collect_tb_top.sv
module irq_collect_tb_top;
   localparam int NCH = 8;
   localparam int NG  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] chg_evt = '0, oc_evt = '0, chg_en = '1, oc_en = '1, live_oc = '0;
   logic [1:0] temp_evt = '0, live_temp = '0;
   logic [NG-1:0] nib_out = 2'b10;
   logic rd_chg = 0, rd_oc = 0, rd_stat = 0, eoi = 0;
   logic [NCH-1:0] chg_msg, oc_msg;
   logic [7:0] stat;
   logic int_n;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   irq_collect dut_i (
      .clk(clk), .rst_n(rst_n), .chg_evt(chg_evt), .oc_evt(oc_evt), .temp_evt(temp_evt),
      .chg_en(chg_en), .oc_en(oc_en), .nib_out(nib_out), .rd_chg(rd_chg), .rd_oc(rd_oc),
      .rd_stat(rd_stat), .eoi(eoi), .live_temp(live_temp), .live_oc(live_oc),
      .chg_msg(chg_msg), .oc_msg(oc_msg), .stat(stat), .int_n(int_n));

   typedef struct packed {
      logic [7:0] chg;
      logic [7:0] oc;
      logic [1:0] tmp;
      logic [2:0] rd;     // {stat, oc, chg}
      logic       eoi;
      logic [1:0] mode;
      logic [7:0] x_chg;
      logic [7:0] x_oc;
      logic [7:0] x_stat;
      logic       x_int;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{8'h13, 8'h11, 2'b00, 3'b000, 1'b0, 2'b10, 8'h03, 8'h10, 8'h90, 1'b0}, // R1 R2 qualify
      '{8'h04, 8'h00, 2'b00, 3'b001, 1'b0, 2'b10, 8'h03, 8'h10, 8'h90, 1'b0}, // R6 read + event
      '{8'h08, 8'h00, 2'b00, 3'b000, 1'b0, 2'b10, 8'h03, 8'h10, 8'h90, 1'b0}, // R6 frozen
      '{8'h00, 8'h00, 2'b00, 3'b000, 1'b1, 2'b10, 8'h0C, 8'h00, 8'h80, 1'b0}, // R7 refill
      '{8'h00, 8'h00, 2'b00, 3'b000, 1'b1, 2'b10, 8'h00, 8'h00, 8'h00, 1'b1}, // R7 empty
      '{8'h01, 8'h20, 2'b00, 3'b000, 1'b0, 2'b10, 8'h01, 8'h20, 8'h90, 1'b0}, // R5
      '{8'h00, 8'h00, 2'b00, 3'b010, 1'b1, 2'b10, 8'h00, 8'h00, 8'h00, 1'b1}, // R7 eoi beats read
      '{8'h02, 8'h00, 2'b00, 3'b001, 1'b0, 2'b10, 8'h00, 8'h00, 8'h00, 1'b0}, // R4 shadow only
      '{8'h00, 8'h00, 2'b00, 3'b000, 1'b1, 2'b10, 8'h02, 8'h00, 8'h80, 1'b0}, // R7
      '{8'h10, 8'h00, 2'b00, 3'b000, 1'b0, 2'b01, 8'h00, 8'h00, 8'h00, 1'b1}, // R9 flip
      '{8'h30, 8'h0F, 2'b00, 3'b000, 1'b0, 2'b01, 8'h30, 8'h0F, 8'h90, 1'b0}, // R1 R2
      '{8'h00, 8'h00, 2'b01, 3'b000, 1'b0, 2'b01, 8'h30, 8'h0F, 8'hB0, 1'b0}, // R3
      '{8'h00, 8'h00, 2'b00, 3'b000, 1'b1, 2'b01, 8'h00, 8'h00, 8'h00, 1'b1}  // R7
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      chg_evt = '0; oc_evt = '0; temp_evt = '0;
      rd_chg = 0; rd_oc = 0; rd_stat = 0; eoi = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset int_n", int_n, 1);
      check("R10 reset regs", {chg_msg, oc_msg, stat}, 0);
      rst_n = 1;
      step();

      for (int k = 0; k < NV; k++) begin
         chg_evt = VEC[k].chg; oc_evt = VEC[k].oc; temp_evt = VEC[k].tmp;
         {rd_stat, rd_oc, rd_chg} = VEC[k].rd; eoi = VEC[k].eoi; nib_out = VEC[k].mode;
         step();
         check($sformatf("R1/R2/R6/R7 row %0d chg", k), chg_msg, VEC[k].x_chg);
         check($sformatf("R2 row %0d oc", k), oc_msg, VEC[k].x_oc);
         check($sformatf("R5 row %0d stat", k), stat, VEC[k].x_stat);
         check($sformatf("R4 row %0d int_n", k), int_n, VEC[k].x_int);
      end

      // R5 live bits
      live_temp = 2'b11; live_oc = 8'h01;
      @(negedge clk);
      check("R5 live bits", stat, 8'h07);
      live_temp = 2'b00; live_oc = 8'h00;

      // R3 R6 R7 temperature freeze with level-2 event in the read cycle
      temp_evt = 2'b01; step();
      check("R3 level1 latch", stat, 8'h20);
      rd_stat = 1; temp_evt = 2'b10; step();
      check("R6 stat frozen", stat, 8'h20);
      check("R4 int low", int_n, 0);
      eoi = 1; step();
      check("R7 level2 refilled", stat, 8'h40);
      check("R4 still low", int_n, 0);
      eoi = 1; step();
      check("R7 temp drained", int_n, 1);

      // R8 enable clear on register
      chg_evt = 8'h40; step();
      check("R8 pre", chg_msg, 8'h40);
      chg_en = 8'hBF; step();
      chg_en = 8'hFF; step();
      check("R8 cleared", chg_msg, 8'h00);
      check("R8 int_n", int_n, 1);

      // R8 enable clear on shadow copy
      rd_chg = 1; chg_evt = 8'h80; step();
      check("R6 shadow int", int_n, 0);
      chg_en = 8'h7F; step();
      check("R8 shadow cleared", int_n, 1);
      chg_en = 8'hFF; eoi = 1; step();
      check("R8 not restored", chg_msg, 8'h00);

      // R2 opposite mode and disabled
      oc_evt = 8'hF0; step();
      check("R2 input pins ignored", {oc_msg, 7'd0, int_n}, {8'h00, 7'd0, 1'b1});
      oc_en = 8'h00; oc_evt = 8'h01; step();
      check("R2 disabled ignored", int_n, 1);
      oc_en = 8'hFF;

      // R9 single-nibble flip
      oc_evt = 8'h01; step();
      check("R9 pre", oc_msg, 8'h01);
      nib_out = 2'b11; step();
      check("R9 flushed", {oc_msg, 7'd0, int_n}, {8'h00, 7'd0, 1'b1});
      nib_out = 2'b01; step();

      // R10 reset mid-run
      chg_evt = 8'h10; step();
      check("R10 pre", chg_msg, 8'h10);
      rst_n = 0; @(negedge clk);
      check("R10 cleared", {chg_msg, stat}, 0);
      check("R10 int_n", int_n, 1);
      rst_n = 1; step();

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule